// File: doc/BRIEF.md
# Keyed Deep-Sleep Entry Controller

This block decides when a chip may drop into deep sleep. Software arms it by writing a two-word unlock sequence over a small register bus. The first word goes to a key register and the second to an arm register. The block grants the request only if four conditions hold: the mode pin shows normal operation, no earlier wakeup is still pending, and each supply the configuration depends on has dropped. When the request is granted, the deep-sleep request output goes high and stays high until a wakeup cause appears.

When a wakeup cause appears, the block does three things on one clock edge. It records the cause in a sticky status bit, sets a pending-wakeup flag and drops the request. Reset-cause pulses are latched in sticky bits of the same status word. Software clears every sticky bit by writing 1 to it.

Top module: `dsleep_gate`

## Requirements
- R1: After reset, sleep_req is 0, status bits [13:0] are 0, the configuration is 0 and the pending-wakeup flag (bit 31 of the arm register, offset 1) reads 0.
- R2: An entry attempt needs two bus writes in consecutive order: 0xAA5555AA to the key register (offset 0), then 0x55AAAA55 to the arm register (offset 1). If any other bus write comes between them, or either value is wrong, the unlock is discarded and no request is raised. Bus reads have no effect on the unlock.
- R3: While mode_pin is 0, an entry attempt is refused. Status bit 16 always shows the present mode_pin level.
- R4: While the pending-wakeup flag is 1, an entry attempt is refused.
- R5: Configuration register (offset 2) bit 0 governs the VDCIN supply and bit 1 governs the VDD supply. When a bit is 0, entry is refused unless that supply's drop input is 1. When a bit is 1, that supply is ignored.
- R6: An accepted arm write raises sleep_req on the next clock edge. sleep_req then stays high until a wake cause occurs.
- R7: While sleep_req is 1, wake causes set status bits on the same edge that clears sleep_req and sets the pending-wakeup flag. The causes are mode_pin at 0 (bit 0) and wake_evt[i] (bit i+1), where the events are crystal, low-speed clock, analog, timer and pin. A supply whose configuration bit is 0 and whose drop input reads 0 also counts as the analog cause (bit 3). Wake events while sleep_req is 0 set nothing.
- R8: A pulse on rst_evt[k] sets status bit 8+k at any time, whether or not sleep_req is high.
- R9: Writing 1 to a status bit (offset 3) clears it. Writing a value with bit 31 set to the arm register clears the pending-wakeup flag, unless that value is the arm key. When a bit is set and cleared in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 2 | Register offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| mode_pin | input | 1 | 1 = normal, 0 = debug |
| vdcin_drop | input | 1 | VDCIN supply has dropped |
| vdd_drop | input | 1 | VDD supply has dropped |
| wake_evt | input | 5 | Wake event pulses: crystal, low-speed clock, analog, timer, pin |
| rst_evt | input | 6 | Reset-cause pulses |
| sleep_req | output | 1 | Deep-sleep request |
| status_o | output | 32 | Status word |

## Verification
Two functions can collide in one cycle: a wake cause setting a sticky bit, and a software write-1-to-clear of that same bit. The bench provokes this in two ways. It raises a wake event while sleeping in the same cycle as a clear write to the pending-wakeup flag. It also raises a reset-cause pulse in the same cycle as a clear write to that status bit. In both cases it judges the outcome by reading the bit back on the following cycle and expects 1; a plain clear written afterwards must then give 0.

// File: rtl/dsg_pkg.sv
package dsg_pkg;
   typedef enum logic [1:0] {
      REG_KEY  = 2'd0,
      REG_ARM  = 2'd1,
      REG_CFG  = 2'd2,
      REG_STAT = 2'd3
   } reg_sel_e;

   typedef enum logic {
      UL_IDLE  = 1'b0,
      UL_ARMED = 1'b1
   } unlock_st_e;

   localparam logic [31:0] DEF_PASS_KEY = 32'hAA55_55AA;
   localparam logic [31:0] DEF_ARM_KEY  = 32'h55AA_AA55;
endpackage

// File: rtl/dsg_unlock.sv
module dsg_unlock
   import dsg_pkg::*;
#(
   parameter int          DATA_W   = 32,
   parameter logic [31:0] PASS_KEY = DEF_PASS_KEY,
   parameter logic [31:0] ARM_KEY  = DEF_ARM_KEY
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [1:0]        addr,
   input  logic [DATA_W-1:0] wdata,
   output logic              fire
);
   unlock_st_e st_q;
   logic key_hit;
   logic arm_hit;

   assign key_hit = wr && (addr == REG_KEY) && (wdata == DATA_W'(PASS_KEY));
   assign arm_hit = wr && (addr == REG_ARM) && (wdata == DATA_W'(ARM_KEY));
   assign fire    = (st_q == UL_ARMED) && arm_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q <= UL_IDLE;
      end else if (wr) begin
         if (st_q == UL_ARMED) st_q <= UL_IDLE;
         else if (key_hit)     st_q <= UL_ARMED;
      end
   end
endmodule

// File: rtl/dsg_sticky.sv
module dsg_sticky #(
   parameter int N = 6
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set,
   input  logic [N-1:0] clr,
   output logic [N-1:0] q
);
   for (genvar i = 0; i < N; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      q[i] <= 1'b0;
         else if (set[i]) q[i] <= 1'b1;
         else if (clr[i]) q[i] <= 1'b0;
      end
   end
endmodule

// File: rtl/dsleep_gate.sv
module dsleep_gate
   import dsg_pkg::*;
#(
   parameter int          DATA_W   = 32,
   parameter int          N_WAKE   = 6,
   parameter int          N_RST    = 6,
   parameter int          RST_LSB  = 8,
   parameter int          MODE_POS = 16,
   parameter int          WKU_POS  = 31,
   parameter int          ANA_IDX  = 3,
   parameter logic [31:0] PASS_KEY = DEF_PASS_KEY,
   parameter logic [31:0] ARM_KEY  = DEF_ARM_KEY
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [1:0]        bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              mode_pin,
   input  logic              vdcin_drop,
   input  logic              vdd_drop,
   input  logic [N_WAKE-2:0] wake_evt,
   input  logic [N_RST-1:0]  rst_evt,
   output logic              sleep_req,
   output logic [DATA_W-1:0] status_o
);
   localparam int N_EVT = N_WAKE - 1;

   if (RST_LSB < N_WAKE) begin : g_bad_rst
      $error("reset-cause field overlaps wake field");
   end
   if (MODE_POS < RST_LSB + N_RST || MODE_POS >= DATA_W) begin : g_bad_mode
      $error("mode bit position out of range");
   end
   if (WKU_POS >= DATA_W || ANA_IDX < 1 || ANA_IDX >= N_WAKE) begin : g_bad_misc
      $error("pending bit or analog index out of range");
   end

   logic              fire;
   logic              grant;
   logic [1:0]        cfg_q;
   logic              sleep_q;
   logic              supply_nd;
   logic [N_WAKE-1:0] wake_hit;
   logic              wake_any;
   logic [N_WAKE-1:0] wake_q;
   logic [N_RST-1:0]  rst_q;
   logic              wku_q;
   logic              stat_wr;
   logic              wku_clr;

   dsg_unlock #(
      .DATA_W(DATA_W), .PASS_KEY(PASS_KEY), .ARM_KEY(ARM_KEY)
   ) u_unlock (
      .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr),
      .wdata(bus_wdata), .fire(fire)
   );

   assign grant = fire && mode_pin && !wku_q
                  && (cfg_q[0] || vdcin_drop) && (cfg_q[1] || vdd_drop);

   assign supply_nd = (!cfg_q[0] && !vdcin_drop) || (!cfg_q[1] && !vdd_drop);

   assign wake_hit[0] = sleep_q && !mode_pin;
   for (genvar i = 1; i < N_WAKE; i++) begin : g_wake
      if (i == ANA_IDX) begin : g_ana
         assign wake_hit[i] = sleep_q && (wake_evt[i-1] || supply_nd);
      end else begin : g_plain
         assign wake_hit[i] = sleep_q && wake_evt[i-1];
      end
   end
   assign wake_any = |wake_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        sleep_q <= 1'b0;
      else if (wake_any) sleep_q <= 1'b0;
      else if (grant)    sleep_q <= 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                cfg_q <= 2'b00;
      else if (bus_wr && bus_addr == REG_CFG)    cfg_q <= bus_wdata[1:0];
   end

   assign stat_wr = bus_wr && (bus_addr == REG_STAT);
   assign wku_clr = bus_wr && (bus_addr == REG_ARM) && bus_wdata[WKU_POS]
                    && (bus_wdata != DATA_W'(ARM_KEY));

   dsg_sticky #(.N(N_WAKE)) u_wake_st (
      .clk(clk), .rst_n(rst_n), .set(wake_hit),
      .clr(stat_wr ? bus_wdata[N_WAKE-1:0] : '0), .q(wake_q)
   );

   dsg_sticky #(.N(N_RST)) u_rst_st (
      .clk(clk), .rst_n(rst_n), .set(rst_evt),
      .clr(stat_wr ? bus_wdata[RST_LSB +: N_RST] : '0), .q(rst_q)
   );

   dsg_sticky #(.N(1)) u_wku (
      .clk(clk), .rst_n(rst_n), .set(wake_any), .clr(wku_clr), .q(wku_q)
   );

   always_comb begin
      status_o                     = '0;
      status_o[N_WAKE-1:0]         = wake_q;
      status_o[RST_LSB +: N_RST]   = rst_q;
      status_o[MODE_POS]           = mode_pin;
   end

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         REG_ARM:  bus_rdata[WKU_POS] = wku_q;
         REG_CFG:  bus_rdata[1:0]     = cfg_q;
         REG_STAT: bus_rdata          = status_o;
         default:  bus_rdata          = '0;
      endcase
   end

   assign sleep_req = sleep_q;
endmodule

// File: rtl/dsg_chk.sv
module dsg_chk #(
   parameter int          DATA_W  = 32,
   parameter int          N_WAKE  = 6,
   parameter int          WKU_POS = 31,
   parameter logic [31:0] ARM_KEY = 32'h55AA_AA55
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_wr,
   input logic [1:0]        bus_addr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic              mode_pin,
   input logic              vdcin_drop,
   input logic              vdd_drop,
   input logic [1:0]        cfg,
   input logic              wku,
   input logic              sleep_req,
   input logic [DATA_W-1:0] status_o
);
   // R2
   arm_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sleep_req) |-> $past(bus_wr && bus_addr == 2'd1
                                 && bus_wdata == DATA_W'(ARM_KEY)));
   // R3
   debug_veto_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sleep_req) |-> $past(mode_pin));
   // R4
   pending_veto_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sleep_req) |-> !$past(wku));
   // R5
   supply_veto_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sleep_req) |-> (($past(cfg[0]) || $past(vdcin_drop))
                            && ($past(cfg[1]) || $past(vdd_drop))));
   // R7
   wake_record_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sleep_req) |-> (wku && status_o[N_WAKE-1:0] != '0));
   // R9
   pending_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wku && !(bus_wr && bus_addr == 2'd1 && bus_wdata[WKU_POS])) |=> wku);
endmodule

bind dsleep_gate dsg_chk #(
   .DATA_W(DATA_W), .N_WAKE(N_WAKE), .WKU_POS(WKU_POS), .ARM_KEY(ARM_KEY)
) u_dsg_chk (
   .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
   .bus_wdata(bus_wdata), .mode_pin(mode_pin), .vdcin_drop(vdcin_drop),
   .vdd_drop(vdd_drop), .cfg(cfg_q), .wku(wku_q), .sleep_req(sleep_req),
   .status_o(status_o)
);

// File: tb/test_dsleep_gate.sv
module test_dsleep_gate;
   localparam logic [31:0] PASS = 32'hAA55_55AA;
   localparam logic [31:0] ENK  = 32'h55AA_AA55;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [1:0]  bus_addr = 2'd0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        mode_pin = 1'b1;
   logic        vdcin_drop = 1'b1;
   logic        vdd_drop = 1'b1;
   logic [4:0]  wake_evt = '0;
   logic [5:0]  rst_evt = '0;
   logic        sleep_req;
   logic [31:0] status_o;

   int n_run = 0;
   int n_fail = 0;

   always #4 clk = ~clk;

   dsleep_gate i_dsleep_gate (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mode_pin(mode_pin),
      .vdcin_drop(vdcin_drop), .vdd_drop(vdd_drop), .wake_evt(wake_evt),
      .rst_evt(rst_evt), .sleep_req(sleep_req), .status_o(status_o)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; bus_wr = 1'b0; wake_evt = '0; rst_evt = '0;
      mode_pin = 1'b1; vdcin_drop = 1'b1; vdd_drop = 1'b1;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0; bus_wdata = '0;
   endtask

   task automatic unlock();
      wr(2'd0, PASS);
      wr(2'd1, ENK);
   endtask

   task automatic pending(output logic p);
      bus_addr = 2'd1;
      #1 p = bus_rdata[31];
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      logic p;
      do_reset();
      // R1 reset state
      chk("R1 sleep_req", {31'd0, sleep_req}, 32'd0);
      chk("R1 status", {18'd0, status_o[13:0]}, 32'd0);
      pending(p);
      chk("R1 pending", {31'd0, p}, 32'd0);
      bus_addr = 2'd2; #1;
      chk("R1 cfg", bus_rdata, 32'd0);

      // R2 ordering and corruption
      wr(2'd1, ENK);
      chk("R2 arm without key", {31'd0, sleep_req}, 32'd0);
      wr(2'd1, ENK); wr(2'd0, PASS);
      chk("R2 reversed order", {31'd0, sleep_req}, 32'd0);
      wr(2'd0, PASS); wr(2'd1, ENK ^ 32'h1);
      chk("R2 wrong arm value", {31'd0, sleep_req}, 32'd0);
      wr(2'd1, ENK);
      chk("R2 retry after discard", {31'd0, sleep_req}, 32'd0);
      wr(2'd0, PASS ^ 32'h100); wr(2'd1, ENK);
      chk("R2 wrong key value", {31'd0, sleep_req}, 32'd0);
      wr(2'd0, PASS); wr(2'd2, 32'd0); wr(2'd1, ENK);
      chk("R2 intervening write", {31'd0, sleep_req}, 32'd0);
      wr(2'd0, PASS); bus_addr = 2'd3; @(negedge clk); wr(2'd1, ENK);
      chk("R2 R6 read between is harmless", {31'd0, sleep_req}, 32'd1);
      repeat (3) @(negedge clk);
      chk("R6 request holds", {31'd0, sleep_req}, 32'd1);

      // R3 R4 R5 gating sweep
      for (int k = 0; k < 64; k++) begin
         logic m, w, v, dd, e;
         logic [1:0] c;
         m = k[0]; w = k[1]; c = k[3:2]; v = k[4]; dd = k[5];
         do_reset();
         wr(2'd2, {30'd0, c});
         if (w) begin
            unlock();
            wake_evt = 5'b01000; @(negedge clk); wake_evt = '0;
            wr(2'd3, 32'hFFFF_FFFF);
         end
         mode_pin = m; vdcin_drop = v; vdd_drop = dd;
         @(negedge clk);
         chk("R3 mode visible", {31'd0, status_o[16]}, {31'd0, m});
         unlock();
         e = m & ~w & (c[0] | v) & (c[1] | dd);
         chk($sformatf("R3 R4 R5 gate m=%0d w=%0d c=%0d v=%0d d=%0d", m, w, c, v, dd),
             {31'd0, sleep_req}, {31'd0, e});
      end

      // R7 each wake cause
      for (int s = 0; s < 6; s++) begin
         do_reset();
         unlock();
         chk("R6 enter", {31'd0, sleep_req}, 32'd1);
         if (s == 0) mode_pin = 1'b0; else wake_evt[s-1] = 1'b1;
         @(negedge clk);
         wake_evt = '0; mode_pin = 1'b1;
         chk($sformatf("R7 wake src %0d sleep", s), {31'd0, sleep_req}, 32'd0);
         chk($sformatf("R7 wake src %0d bits", s), {26'd0, status_o[5:0]}, 32'd1 << s);
         pending(p);
         chk("R7 pending set", {31'd0, p}, 32'd1);
      end

      // R7 supply not dropped wakes as analog cause
      for (int sup = 0; sup < 2; sup++) begin
         do_reset();
         unlock();
         if (sup == 0) vdcin_drop = 1'b0; else vdd_drop = 1'b0;
         @(negedge clk);
         chk("R7 supply wake sleep", {31'd0, sleep_req}, 32'd0);
         chk("R7 supply wake bits", {26'd0, status_o[5:0]}, 32'd8);
      end

      // R7 ignored while awake
      do_reset();
      wake_evt = 5'h1F; mode_pin = 1'b0; vdcin_drop = 1'b0;
      @(negedge clk);
      wake_evt = '0; mode_pin = 1'b1; vdcin_drop = 1'b1;
      chk("R7 awake events ignored", {26'd0, status_o[5:0]}, 32'd0);
      pending(p);
      chk("R7 awake pending clear", {31'd0, p}, 32'd0);

      // R8 reset causes, R9 clears
      for (int k = 0; k < 6; k++) begin
         rst_evt[k] = 1'b1; @(negedge clk); rst_evt = '0;
         chk($sformatf("R8 cause %0d", k), {26'd0, status_o[13:8]}, 32'd1 << k);
         wr(2'd3, 32'd1 << (k + 8));
         chk($sformatf("R9 cause %0d cleared", k), {26'd0, status_o[13:8]}, 32'd0);
      end

      // R9 set beats clear: status bit
      rst_evt[2] = 1'b1; wr(2'd3, 32'd1 << 10); rst_evt = '0;
      chk("R9 set wins on status", {31'd0, status_o[10]}, 32'd1);
      wr(2'd3, 32'd1 << 10);
      chk("R9 status cleared", {31'd0, status_o[10]}, 32'd0);

      // R9 set beats clear: pending flag, plus R4 re-entry after clear
      unlock();
      wake_evt[0] = 1'b1; wr(2'd1, 32'h8000_0000); wake_evt = '0;
      pending(p);
      chk("R9 set wins on pending", {31'd0, p}, 32'd1);
      unlock();
      chk("R4 refused while pending", {31'd0, sleep_req}, 32'd0);
      wr(2'd1, 32'h8000_0000);
      pending(p);
      chk("R9 pending cleared", {31'd0, p}, 32'd0);
      wr(2'd3, 32'h0000_003F);
      chk("R9 wake bits cleared", {26'd0, status_o[5:0]}, 32'd0);
      unlock();
      chk("R4 entry after clear", {31'd0, sleep_req}, 32'd1);

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule